// File: doc/BRIEF.md
# Output-Stationary 2x2 Systolic Matrix Multiplier

This block multiplies two small square matrices of unsigned 4-bit elements on a grid of multiply-accumulate cells. Every cell keeps one element of the product in its own accumulator. Only the operands move. Elements of A travel rightward along the rows, and elements of B travel downward along the columns, one cell per clock. A feeder inside the block captures both matrices from parallel input ports when it sees a start pulse. It then streams A and B into the grid. Each row after the first, and each column after the first, is delayed by one extra cycle per index, so the matching operands meet in the right cell without any outside scheduling.

A client places both matrices on the input ports and pulses `start` for one clock. A fixed number of edges later, `done` rises. The four results can then be read from the result port, and they stay there until the next start. The operands that leave the far right column and the bottom row are brought out on pass-through ports, so a wider arrangement could chain further cells from them.

Top module: `sysmat_top`

## Requirements
- R1: While reset is asserted, and after reset until the first start, `done_o` is 0 and `c_mat_o`, `a_east_o` and `b_south_o` are all zero.
- R2: When `done_o` is high, the 8-bit field at bits [(i*2+j)*8 +: 8] of `c_mat_o` equals C[i][j] = A[i][0]·B[0][j] + A[i][1]·B[1][j]. Element A[i][k] is taken from bits [(i*2+k)*4 +: 4] of `a_mat_i`, and element B[k][j] from bits [(k*2+j)*4 +: 4] of `b_mat_i`.
- R3: `done_o` is low through the third rising edge after the start edge and is high after the fourth. It then stays high until the next start.
- R4: A start edge clears every accumulator and drops `done_o`. In the cycle after the start edge, all of `c_mat_o` reads zero and `done_o` is 0.
- R5: The operands are sampled only on the start edge. Changes on `a_mat_i` or `b_mat_i` after that edge have no effect on the results.
- R6: Element A[r][k] appears on bits [r*4 +: 4] of `a_east_o` in the cycle after rising edge k+r+2 that follows the start edge. Element B[k][c] appears on bits [c*4 +: 4] of `b_south_o` in the cycle after edge k+c+2. At all other times these ports read zero.
- R7: Each result wraps modulo 256, with no saturation. For example, all-15 operands give 194 in every element.
- R8: A start that arrives while a multiplication is in progress abandons it. The block then produces the correct result for the operands sampled on the new start, with the same timing as R3.
- R9: While `done_o` is high and no start arrives, `c_mat_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | One-cycle pulse: sample operands, clear accumulators, begin streaming |
| a_mat_i | input | 16 | Matrix A, element (i,k) at bits (i*2+k)*4 |
| b_mat_i | input | 16 | Matrix B, element (k,j) at bits (k*2+j)*4 |
| c_mat_o | output | 32 | Product C, element (i,j) at bits (i*2+j)*8 |
| done_o | output | 1 | High once all products are accumulated, until next start |
| a_east_o | output | 8 | A operands leaving the right edge, row r at bits r*4 |
| b_south_o | output | 8 | B operands leaving the bottom edge, column c at bits c*4 |

## Verification
The assertions assume that `start` is a synchronous input. They also assume that reset is released away from a clock edge, so that every property measures its cycles from a clean idle state. The accumulator and done properties further assume that a start can only arrive on a clock edge. The operand ports need to be valid only on that edge. The bench changes every input at the falling edge, keeps `start` high for exactly one rising edge per run, and sometimes changes the operand ports straight after a start. This shows that nothing other than the start edge samples them.

// File: rtl/sysmat_pkg.sv
package sysmat_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // Step index of the last accumulating cycle: the final operand pair
  // needs (N-1) feed steps, (N-1) skew stages and (N-1) hops.
  function automatic int last_step(input int n);
    return 3 * n - 3;
  endfunction

endpackage

// File: rtl/sysmat_skew.sv
module sysmat_skew #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [DEPTH];
  logic [W-1:0] st_d [DEPTH];

  always_comb begin
    if (clr_i) begin
      for (int s = 0; s < DEPTH; s++) st_d[s] = '0;
    end else begin
      st_d[0] = d_i;
      for (int s = 1; s < DEPTH; s++) st_d[s] = st_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) st_q[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) st_q[s] <= st_d[s];
    end
  end

  assign q_o = st_q[DEPTH-1];

endmodule

// File: rtl/sysmat_feeder.sv
module sysmat_feeder
  import sysmat_pkg::*;
#(
  parameter int N   = 2,
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [N*N*OPW-1:0] a_mat_i,
  input  logic [N*N*OPW-1:0] b_mat_i,
  output logic [N*OPW-1:0] a_row_o,
  output logic [N*OPW-1:0] b_col_o,
  output logic             clr_o,
  output logic             acc_en_o,
  output logic             done_o
);

  localparam int LAST = last_step(N);
  localparam int CW   = $clog2(LAST + 1) + 1;
  localparam int EL   = N * N;

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   step_q, step_d;
  logic [OPW-1:0]  a_hold_q [EL];
  logic [OPW-1:0]  a_hold_d [EL];
  logic [OPW-1:0]  b_hold_q [EL];
  logic [OPW-1:0]  b_hold_d [EL];
  logic [OPW-1:0]  row_raw  [N];
  logic [OPW-1:0]  col_raw  [N];

  // Next state: sequencing and operand capture
  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    for (int e = 0; e < EL; e++) begin
      a_hold_d[e] = a_hold_q[e];
      b_hold_d[e] = b_hold_q[e];
    end
    if (start_i) begin
      phase_d = PH_RUN;
      step_d  = '0;
      for (int e = 0; e < EL; e++) begin
        a_hold_d[e] = a_mat_i[e*OPW +: OPW];
        b_hold_d[e] = b_mat_i[e*OPW +: OPW];
      end
    end else if (phase_q == PH_RUN) begin
      if (step_q == CW'(LAST)) phase_d = PH_DONE;
      else                     step_d  = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      for (int e = 0; e < EL; e++) begin
        a_hold_q[e] <= '0;
        b_hold_q[e] <= '0;
      end
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      for (int e = 0; e < EL; e++) begin
        a_hold_q[e] <= a_hold_d[e];
        b_hold_q[e] <= b_hold_d[e];
      end
    end
  end

  // Unskewed streams: element k of each row/column at step k, zero otherwise
  always_comb begin
    for (int r = 0; r < N; r++) begin
      row_raw[r] = '0;
      col_raw[r] = '0;
      if (phase_q == PH_RUN && step_q < CW'(N)) begin
        row_raw[r] = a_hold_q[r*N + int'(step_q)];
        col_raw[r] = b_hold_q[int'(step_q)*N + r];
      end
    end
  end

  // Staircase skew: row/column r is delayed by r cycles
  for (genvar r = 0; r < N; r++) begin : g_skew
    if (r == 0) begin : g_direct
      assign a_row_o[r*OPW +: OPW] = row_raw[r];
      assign b_col_o[r*OPW +: OPW] = col_raw[r];
    end else begin : g_delay
      sysmat_skew #(.W(OPW), .DEPTH(r)) u_sk_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_i),
        .d_i   (row_raw[r]),
        .q_o   (a_row_o[r*OPW +: OPW])
      );
      sysmat_skew #(.W(OPW), .DEPTH(r)) u_sk_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_i),
        .d_i   (col_raw[r]),
        .q_o   (b_col_o[r*OPW +: OPW])
      );
    end
  end

  assign clr_o    = start_i;
  assign acc_en_o = (phase_q == PH_RUN);
  assign done_o   = (phase_q == PH_DONE);

  // R3: done remains high until a new start
  assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  // R3: the step counter never runs past the last accumulating step
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en_o |-> step_q <= CW'(LAST));

  // R4: a start always drops done on the following cycle
  assert_start_drops_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);

endmodule

// File: rtl/sysmat_cell.sv
module sysmat_cell #(
  parameter int OPW  = 4,
  parameter int ACCW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  output logic [OPW-1:0]  a_o,
  output logic [OPW-1:0]  b_o,
  output logic [ACCW-1:0] acc_o
);

  localparam int PW = 2 * OPW;
  localparam int SW = (ACCW > PW) ? ACCW : PW;

  logic [ACCW-1:0] acc_q, acc_d;
  logic [OPW-1:0]  a_q, a_d, b_q, b_d;
  logic [PW-1:0]   prod;
  logic [SW-1:0]   sum_w;

  always_comb begin
    prod  = PW'(a_i) * PW'(b_i);
    sum_w = SW'(acc_q) + SW'(prod);
    a_d   = clr_i ? '0 : a_i;
    b_d   = clr_i ? '0 : b_i;
    if (clr_i)     acc_d = '0;
    else if (en_i) acc_d = sum_w[ACCW-1:0];
    else           acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      acc_q <= acc_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  assign a_o   = a_q;
  assign b_o   = b_q;
  assign acc_o = acc_q;

  // R4: clear forces the accumulator to zero on the next cycle
  assert_acc_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_o == '0);

  // R9: with accumulation disabled the sum is held
  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && !clr_i |=> $stable(acc_o));

endmodule

// File: rtl/sysmat_top.sv
module sysmat_top #(
  parameter int N    = 2,
  parameter int OPW  = 4,
  parameter int ACCW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N*N*OPW-1:0]    a_mat_i,
  input  logic [N*N*OPW-1:0]    b_mat_i,
  output logic [N*N*ACCW-1:0]   c_mat_o,
  output logic                  done_o,
  output logic [N*OPW-1:0]      a_east_o,
  output logic [N*OPW-1:0]      b_south_o
);

  logic [N*OPW-1:0] a_left, b_top;
  logic             clr, acc_en;
  logic [OPW-1:0]   a_h [N][N+1];
  logic [OPW-1:0]   b_v [N+1][N];

  sysmat_feeder #(.N(N), .OPW(OPW)) u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .a_mat_i  (a_mat_i),
    .b_mat_i  (b_mat_i),
    .a_row_o  (a_left),
    .b_col_o  (b_top),
    .clr_o    (clr),
    .acc_en_o (acc_en),
    .done_o   (done_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign a_h[i][0] = a_left[i*OPW +: OPW];
    assign b_v[0][i] = b_top[i*OPW +: OPW];
    assign a_east_o[i*OPW +: OPW]  = a_h[i][N];
    assign b_south_o[i*OPW +: OPW] = b_v[N][i];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      sysmat_cell #(.OPW(OPW), .ACCW(ACCW)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .en_i  (acc_en),
        .a_i   (a_h[i][j]),
        .b_i   (b_v[i][j]),
        .a_o   (a_h[i][j+1]),
        .b_o   (b_v[i+1][j]),
        .acc_o (c_mat_o[(i*N+j)*ACCW +: ACCW])
      );
    end
  end

  // R9: results are frozen while done is high and no restart comes
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start |=> $stable(c_mat_o));

  // R3: done and accumulation never overlap
  assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && acc_en));

endmodule

// File: tb/sim_sysmat_top.sv
module sim_sysmat_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] a_mat, b_mat;
  wire  [31:0] c_mat;
  wire         done;
  wire  [7:0]  a_east, b_south;

  int checks = 0;
  int errors = 0;
  int ma [2][2];
  int mb [2][2];

  always #2 clk = ~clk;

  sysmat_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .a_mat_i   (a_mat),
    .b_mat_i   (b_mat),
    .c_mat_o   (c_mat),
    .done_o    (done),
    .a_east_o  (a_east),
    .b_south_o (b_south)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_c(input int i, input int j);
    return (ma[i][0] * mb[0][j] + ma[i][1] * mb[1][j]) % 256;
  endfunction

  task automatic set_ops(input int a00, input int a01, input int a10, input int a11,
                         input int b00, input int b01, input int b10, input int b11);
    ma[0][0] = a00; ma[0][1] = a01; ma[1][0] = a10; ma[1][1] = a11;
    mb[0][0] = b00; mb[0][1] = b01; mb[1][0] = b10; mb[1][1] = b11;
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < 2; k++) begin
        a_mat[(i*2+k)*4 +: 4] = 4'(ma[i][k]);
        b_mat[(i*2+k)*4 +: 4] = 4'(mb[i][k]);
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic check_results(input string req);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++)
        chk(req, int'(c_mat[(i*2+j)*8 +: 8]), ref_c(i, j));
  endtask

  // Start, check clearing (R4), done timing (R3) and results
  task automatic run_full(input string req);
    pulse_start();
    chk("R4 done low after start", int'(done), 0);
    chk("R4 results cleared", int'(c_mat), 0);
    repeat (3) @(negedge clk);
    chk("R3 done low after third edge", int'(done), 0);
    @(negedge clk);
    chk("R3 done high after fourth edge", int'(done), 1);
    check_results(req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    a_mat = '0;
    b_mat = '0;
    #11;
    chk("R1 done in reset", int'(done), 0);
    chk("R1 results in reset", int'(c_mat), 0);
    chk("R1 east in reset", int'(a_east), 0);
    chk("R1 south in reset", int'(b_south), 0);
    @(negedge clk) rst_n = 1'b1;
    set_ops(3, 5, 7, 9, 2, 4, 6, 8);
    repeat (3) @(negedge clk);
    chk("R1 done idle", int'(done), 0);
    chk("R1 results idle", int'(c_mat), 0);
  endtask

  task automatic t_basic();
    set_ops(1, 2, 3, 4, 5, 6, 7, 8);
    run_full("R2 basic product");
    chk("R2 c00 value", int'(c_mat[7:0]), 19);
    chk("R2 c11 value", int'(c_mat[31:24]), 50);
  endtask

  task automatic t_identity();
    set_ops(1, 0, 0, 1, 7, 3, 11, 13);
    run_full("R2 identity");
    set_ops(0, 6, 10, 0, 2, 9, 14, 1);
    run_full("R2 anti-diagonal");
  endtask

  task automatic t_wrap();
    set_ops(15, 15, 15, 15, 15, 15, 15, 15);
    run_full("R7 wrap");
    chk("R7 wrapped to 194", int'(c_mat[15:8]), 194);
  endtask

  task automatic t_passthru();
    set_ops(1, 2, 3, 4, 5, 6, 7, 8);
    pulse_start();
    for (int t = 1; t <= 6; t++) begin
      @(negedge clk);
      for (int r = 0; r < 2; r++) begin
        int k;
        int ea;
        int eb;
        k  = t - r - 2;
        ea = (k >= 0 && k < 2) ? ma[r][k] : 0;
        eb = (k >= 0 && k < 2) ? mb[k][r] : 0;
        chk("R6 east operand", int'(a_east[r*4 +: 4]), ea);
        chk("R6 south operand", int'(b_south[r*4 +: 4]), eb);
      end
    end
  endtask

  task automatic t_ignore();
    set_ops(2, 3, 4, 5, 6, 7, 8, 9);
    pulse_start();
    a_mat = 16'hFFFF;
    b_mat = 16'hA5C3;
    repeat (4) @(negedge clk);
    chk("R5 done after late input change", int'(done), 1);
    check_results("R5 inputs ignored after start");
  endtask

  task automatic t_hold();
    set_ops(4, 1, 2, 3, 5, 0, 1, 7);
    run_full("R9 setup");
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      a_mat = 16'(n * 4099);
      b_mat = 16'(n * 1237);
    end
    chk("R3 done stays high", int'(done), 1);
    check_results("R9 results held");
  endtask

  task automatic t_restart();
    set_ops(9, 9, 9, 9, 9, 9, 9, 9);
    pulse_start();
    repeat (2) @(negedge clk);
    set_ops(1, 3, 2, 4, 5, 2, 1, 3);
    run_full("R8 restart mid-run");
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_identity();
    t_wrap();
    t_passthru();
    t_ignore();
    t_hold();
    t_restart();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule